// File: doc/BRIEF.md
# Run-Length Configuration Bitstream Expander

This block turns a byte-coded, run-length compressed configuration image into the serial bit stream that a configuration shifter clocks into a programmable device. Bytes arrive on a valid/ready input channel and bits leave one at a time on a valid/ready output channel. The shifter that drives the device pins and the handshake with the device are not part of this block.

On each new stream the block first hunts for a start marker and discards every byte until it has seen it. The marker is a byte of 0xFF followed by a byte whose upper nibble is 3. The block then sends a fixed 16-bit synchronisation word. After that, each further input byte is one code and is expanded into a run of equal bits, which may be closed by a single bit of the opposite value. The input carries a last-byte flag. The output marks the final bit of the final code. After that code the block goes back to hunting for the next marker.

The control is a six-state machine:
- `ST_HUNT` accepts bytes and moves to `ST_ARMED` on 0xFF.
- `ST_ARMED` moves to `ST_HEADER` on a byte with upper nibble 3, stays in `ST_ARMED` on another 0xFF, and returns to `ST_HUNT` on any other byte.
- `ST_HEADER` sends the 16 sync bits and moves to `ST_FETCH` once the last of them is taken.
- `ST_FETCH` accepts one code byte. It goes to `ST_RUN` if the run is not empty, to `ST_TERM` if the code has only a closing bit, and otherwise to `ST_FETCH` or `ST_HUNT`, depending on the last flag.
- `ST_RUN` sends the run bits. After the final one it goes to `ST_TERM` if a closing bit follows, and otherwise to `ST_FETCH`, or to `ST_HUNT` when the byte was flagged last.
- `ST_TERM` sends the closing bit and then goes to `ST_FETCH`, or to `ST_HUNT` when the byte was flagged last.

Top module: `rle_bitstream_expander`

## Requirements
- R1: After reset, and after a stream ends, input bytes are discarded until a 0xFF byte is directly followed by a byte whose bits [7:4] equal 4'h3. The byte after that pair is the first code.
- R2: Once the marker is found, and before any decoded bit, the output carries the 16 bits of 16'hFF20, most significant bit first.
- R3: A code n with 1 <= n <= 226 produces n bits of value 1 followed by one bit of value 0.
- R4: The code 227 produces 226 bits of value 1 and no closing 0.
- R5: A code n with 228 <= n <= 254 produces (n - 228) bits of value 0 followed by one bit of value 1, so 228 yields a single 1.
- R6: The code 255 produces a single bit of value 1.
- R7: The code 0 produces no output bit. If it carries the last flag, the block returns to marker search without asserting out_last.
- R8: in_ready is low whenever out_valid is high. The next byte is accepted only after the final bit of the current header or run has been taken.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_bit and out_last hold their values into the next cycle.
- R10: out_last is high only on the final bit produced by the code byte that carried in_last. After that bit is taken, the block is back in marker search.
- R11: Out of reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| in_data | input | 8 | Input byte: marker search byte or code |
| in_last | input | 1 | Marks the final code byte of a stream |
| out_valid | output | 1 | Output bit is valid |
| out_ready | input | 1 | Consumer takes the output bit this cycle |
| out_bit | output | 1 | Serial configuration bit |
| out_last | output | 1 | Marks the final bit of the stream |

## Verification
The embedded assertions check the following on every cycle:
- The output is held through consumer stalls.
- out_last never appears without out_valid.
- The input and output sides never handshake in the same cycle.
- The run counter stays non-zero and within the maximum run length while a run is being sent.
- The block is back in marker search after the final bit is taken.

Only the directed scenarios can show that the bit sequence itself is right. These cover the marker search through false starts, the exact sync word, and the length and value of each code range at its end points. They also cover the silent effect of a zero code, including a zero code that ends a stream, and the discarding of stray bytes between streams.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ARMED,
        ST_HEADER,
        ST_FETCH,
        ST_RUN,
        ST_TERM
    } exp_state_t;

endpackage

// File: rtl/rle_marker_match.sv
module rle_marker_match #(
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  LEAD     = 8'hFF,
    parameter logic [3:0]  TAIL_NIB = 4'h3
) (
    input  logic [BYTE_W-1:0] byte_in,
    output logic              is_lead,
    output logic              is_tail
);
    localparam int NIB_LO = BYTE_W - 4;

    always_comb begin
        is_lead = (byte_in == LEAD);
        is_tail = (byte_in[BYTE_W-1:NIB_LO] == TAIL_NIB);
    end

endmodule

// File: rtl/rle_code_decode.sv
module rle_code_decode #(
    parameter int BYTE_W   = 8,
    parameter int MAX_ONES = 226,
    parameter int CNT_W    = 8
) (
    input  logic [BYTE_W-1:0] code,
    output logic [CNT_W-1:0]  run_len,
    output logic              run_val,
    output logic              has_term
);
    localparam logic [BYTE_W-1:0] FULL_CODE = BYTE_W'(MAX_ONES + 1);
    localparam logic [BYTE_W-1:0] ZERO_BASE = BYTE_W'(MAX_ONES + 2);
    localparam logic [BYTE_W-1:0] SOLO_CODE = {BYTE_W{1'b1}};

    logic [BYTE_W-1:0] zero_len;

    always_comb begin
        zero_len = code - ZERO_BASE;
        run_len  = '0;
        run_val  = 1'b0;
        has_term = 1'b0;
        if (code == '0) begin
            run_len  = '0;
            has_term = 1'b0;
        end else if (code <= BYTE_W'(MAX_ONES)) begin
            run_len  = CNT_W'(code);
            run_val  = 1'b1;
            has_term = 1'b1;
        end else if (code == FULL_CODE) begin
            run_len  = CNT_W'(MAX_ONES);
            run_val  = 1'b1;
            has_term = 1'b0;
        end else if (code != SOLO_CODE) begin
            run_len  = CNT_W'(zero_len);
            run_val  = 1'b0;
            has_term = 1'b1;
        end else begin
            run_len  = '0;
            run_val  = 1'b0;
            has_term = 1'b1;
        end
    end

endmodule

// File: rtl/rle_sync_header.sv
module rle_sync_header #(
    parameter int                HDR_W = 16,
    parameter logic [HDR_W-1:0]  HDR   = 16'hFF20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic step,
    output logic hdr_bit,
    output logic hdr_final
);
    localparam int IDX_W = $clog2(HDR_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_W - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (active && step) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        pos       = IDX_LAST - idx_q;
        hdr_bit   = HDR[pos];
        hdr_final = (idx_q == IDX_LAST);
    end

    // R2
    hdr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(idx_q));

endmodule

// File: rtl/rle_bitstream_expander.sv
module rle_bitstream_expander #(
    parameter int          MAX_ONES = 226,
    parameter int          HDR_W    = 16,
    parameter logic [15:0] HDR      = 16'hFF20,
    parameter logic [7:0]  LEAD     = 8'hFF,
    parameter logic [3:0]  TAIL_NIB = 4'h3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_bit,
    output logic       out_last
);
    import rle_pkg::*;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(MAX_ONES + 1);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    exp_state_t       state_q, state_d;
    logic [CNT_W-1:0] run_cnt_q, run_cnt_d;
    logic             run_val_q, run_val_d;
    logic             term_q, term_d;
    logic             last_q, last_d;

    logic             in_fire, out_fire;
    logic             is_lead, is_tail;
    logic [CNT_W-1:0] dec_len;
    logic             dec_val, dec_term;
    logic             hdr_bit, hdr_final;
    logic             in_header;

    rle_marker_match #(
        .BYTE_W  (BYTE_W),
        .LEAD    (LEAD),
        .TAIL_NIB(TAIL_NIB)
    ) u_marker (
        .byte_in(in_data),
        .is_lead(is_lead),
        .is_tail(is_tail)
    );

    rle_code_decode #(
        .BYTE_W  (BYTE_W),
        .MAX_ONES(MAX_ONES),
        .CNT_W   (CNT_W)
    ) u_decode (
        .code    (in_data),
        .run_len (dec_len),
        .run_val (dec_val),
        .has_term(dec_term)
    );

    rle_sync_header #(
        .HDR_W(HDR_W),
        .HDR  (HDR_W'(HDR))
    ) u_header (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (in_header),
        .step     (out_fire),
        .hdr_bit  (hdr_bit),
        .hdr_final(hdr_final)
    );

    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign in_header = (state_q == ST_HEADER);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_HUNT;
            run_cnt_q <= '0;
            run_val_q <= 1'b0;
            term_q    <= 1'b0;
            last_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            run_cnt_q <= run_cnt_d;
            run_val_q <= run_val_d;
            term_q    <= term_d;
            last_q    <= last_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        run_cnt_d = run_cnt_q;
        run_val_d = run_val_q;
        term_d    = term_q;
        last_d    = last_q;
        unique case (state_q)
            ST_HUNT: begin
                if (in_fire && is_lead) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (in_fire) begin
                    if (is_tail)      state_d = ST_HEADER;
                    else if (is_lead) state_d = ST_ARMED;
                    else              state_d = ST_HUNT;
                end
            end
            ST_HEADER: begin
                if (out_fire && hdr_final) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (in_fire) begin
                    run_cnt_d = dec_len;
                    run_val_d = dec_val;
                    term_d    = dec_term;
                    last_d    = in_last;
                    if (dec_len != '0) state_d = ST_RUN;
                    else if (dec_term) state_d = ST_TERM;
                    else if (in_last)  state_d = ST_HUNT;
                    else               state_d = ST_FETCH;
                end
            end
            ST_RUN: begin
                if (out_fire) begin
                    run_cnt_d = run_cnt_q - 1'b1;
                    if (run_cnt_q == ONE_LEFT) begin
                        if (term_q)      state_d = ST_TERM;
                        else if (last_q) state_d = ST_HUNT;
                        else             state_d = ST_FETCH;
                    end
                end
            end
            ST_TERM: begin
                if (out_fire) state_d = last_q ? ST_HUNT : ST_FETCH;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_HUNT, ST_ARMED, ST_FETCH: in_ready = 1'b1;
            ST_HEADER: begin
                out_valid = 1'b1;
                out_bit   = hdr_bit;
            end
            ST_RUN: begin
                out_valid = 1'b1;
                out_bit   = run_val_q;
                out_last  = last_q && !term_q && (run_cnt_q == ONE_LEFT);
            end
            ST_TERM: begin
                out_valid = 1'b1;
                out_bit   = ~run_val_q;
                out_last  = last_q;
            end
            default: ;
        endcase
    end

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

    // R10
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10
    rehunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (state_q == ST_HUNT));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_fire && out_fire));

    // R3
    run_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (run_cnt_q != '0 && run_cnt_q <= CNT_W'(MAX_ONES)));

endmodule

// File: tb/sim_rle_bitstream_expander.sv
`timescale 1ns/1ps
module sim_rle_bitstream_expander;
    typedef int q_t[$];

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       in_last;
    logic       out_valid;
    logic       out_ready;
    logic       out_bit;
    logic       out_last;

    int   checks = 0;
    int   fails  = 0;
    bit   got_q[$];
    int   last_pos[$];
    bit   exp_q[$];
    logic stall_en = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    int   overlap = 0;
    int   hold_viol = 0;
    logic prev_stall = 1'b0;
    logic prev_bit = 1'b0;
    logic prev_last = 1'b0;

    always #2 clk = ~clk;

    rle_bitstream_expander u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_last  (in_last),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_bit  (out_bit),
        .out_last (out_last)
    );

    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = stall_en ? lfsr[0] : 1'b1;
            if (rst_n) begin
                if (prev_stall && (!out_valid || out_bit != prev_bit || out_last != prev_last))
                    hold_viol++;
                if (in_ready && out_valid) overlap++;
                if (out_valid && out_ready) begin
                    got_q.push_back(out_bit);
                    if (out_last) last_pos.push_back(got_q.size() - 1);
                end
                prev_stall = out_valid && !out_ready;
                prev_bit   = out_bit;
                prev_last  = out_last;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic add_code(input int c);
        if (c >= 1 && c <= 226) begin
            for (int k = 0; k < c; k++) exp_q.push_back(1'b1);
            exp_q.push_back(1'b0);
        end else if (c == 227) begin
            for (int k = 0; k < 226; k++) exp_q.push_back(1'b1);
        end else if (c >= 228 && c <= 254) begin
            for (int k = 0; k < c - 228; k++) exp_q.push_back(1'b0);
            exp_q.push_back(1'b1);
        end else if (c == 255) begin
            exp_q.push_back(1'b1);
        end
    endtask

    task automatic send_byte(input int b, input bit lst);
        in_valid = 1'b1;
        in_data  = 8'(b);
        in_last  = lst;
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_stream(input q_t prefix, input q_t codes, input bit want_last,
                              input string req);
        logic [15:0] hw;
        int w;
        int bad;
        got_q.delete();
        last_pos.delete();
        exp_q.delete();
        overlap = 0;
        hold_viol = 0;
        hw = 16'hFF20;
        for (int k = 15; k >= 0; k--) exp_q.push_back(hw[k]);
        foreach (codes[k]) add_code(codes[k]);
        foreach (prefix[k]) send_byte(prefix[k], 1'b0);
        foreach (codes[k]) send_byte(codes[k], k == codes.size() - 1);
        w = 0;
        while (got_q.size() < exp_q.size() && w < 5000) begin
            @(negedge clk);
            w++;
        end
        repeat (10) @(negedge clk);
        chk(got_q.size() == exp_q.size(), req, "bit count", got_q.size(), exp_q.size());
        bad = 0;
        foreach (exp_q[k]) if (k < got_q.size() && got_q[k] != exp_q[k]) bad++;
        chk(bad == 0, req, "mismatched bits", bad, 0);
        if (want_last)
            chk(last_pos.size() == 1 && last_pos[0] == exp_q.size() - 1, "R10",
                "last position", (last_pos.size() > 0) ? last_pos[0] : -1, exp_q.size() - 1);
        else
            chk(last_pos.size() == 0, "R7", "out_last count", last_pos.size(), 0);
        chk(overlap == 0, "R8", "ready during output", overlap, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        in_last = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    endtask

    // R1 false starts, R2 header, R3 short run
    task automatic t_marker();
        run_stream('{8'h12, 8'hFF, 8'h45, 8'hFF, 8'hFF, 8'h3A}, '{3}, 1'b1, "R1");
    endtask

    // R3 end points of the ones range
    task automatic t_ones();
        run_stream('{8'hFF, 8'h30}, '{1, 226, 5}, 1'b1, "R3");
    endtask

    // R4 full run without closing zero
    task automatic t_full();
        run_stream('{8'hFF, 8'h3F}, '{227, 227, 2}, 1'b1, "R4");
    endtask

    // R5 zero runs and R6 solo one
    task automatic t_zeros();
        run_stream('{8'hFF, 8'h35}, '{228, 230, 254, 255}, 1'b1, "R5");
        run_stream('{8'hFF, 8'h31}, '{255, 255}, 1'b1, "R6");
    endtask

    // R7 zero code inside a stream and as the last code
    task automatic t_zero_code();
        run_stream('{8'hFF, 8'h32}, '{0, 4, 0, 1}, 1'b1, "R7");
        run_stream('{8'hFF, 8'h33}, '{2, 0}, 1'b0, "R7");
    endtask

    // R9 consumer stalls
    task automatic t_stall();
        stall_en = 1'b1;
        run_stream('{8'hFF, 8'h34}, '{6, 229, 227, 255, 1}, 1'b1, "R9");
        chk(hold_viol == 0, "R9", "output changed while stalled", hold_viol, 0);
        stall_en = 1'b0;
    endtask

    // R10 stray bytes after a finished stream are discarded
    task automatic t_rehunt();
        run_stream('{8'h07, 8'h30, 8'hFF, 8'h31}, '{1}, 1'b1, "R10");
    endtask

    initial begin
        t_reset();
        t_marker();
        t_ones();
        t_full();
        t_zeros();
        t_zero_code();
        t_stall();
        t_rehunt();
        summary();
        $finish;
    end

endmodule